// File: doc/BRIEF.md
# Message-Signalling Interrupt Controller

This block collects a vector of level interrupt inputs from peripherals and tells the processor about them by issuing a memory write instead of driving an interrupt wire. Each rising edge on an input is recorded in a pending register, whether or not the input is enabled. If the input is also enabled in the mask register, the edge is recorded in a sticky request register and, unless the control register reports a bus error, a message write is scheduled.

The message is a single 32-bit write. Its address and its data both come from one programmable message-address register: the address is that register with its low five bits cleared, and the data is those five bits, zero-extended. Messages leave through a master port with a valid/ready handshake. Edges that arrive while a message is still waiting are counted in a small saturating queue and sent one after another. Software reaches the registers through a simple register bus slave with big-endian byte strobes and combinational read data.

Top module: `msgirq_ctrl`

## Requirements
- R1: A rising edge on input i sets bit i of the pending register (offset 0x08) one clock later, whether or not bit i is enabled in the mask register (offset 0x04).
- R2: A rising edge on an input whose mask bit is set sets the same bit of the request register (offset 0x00); request bits stay set until reset, and bus writes to the request register have no effect.
- R3: Every clock cycle that contains at least one enabled edge yields exactly one message, so an input held high sends one message; the message address is the message-address register (offset 0x10) with bits 4:0 cleared and the data is its bits 4:0 zero-extended, both taken when the message is launched.
- R4: Once msg_valid is high it stays high, with msg_addr and msg_data unchanged, until a cycle in which msg_ready is high.
- R5: Message events that arrive while a message is outstanding are queued and sent later; with CNT_W = 2 the queue holds at most 3 events beyond the one in flight, and further events are dropped.
- R6: While bit 0 of the control register (offset 0x0C) is set, enabled edges launch no message, but the request bit is still recorded.
- R7: A read of the pending register returns its current value and clears it; any write to it clears it regardless of data or strobes.
- R8: A read of the control register returns bit 0 only, other bits zero; writes store the full word.
- R9: After reset the message-address register reads 0xFFFB0003, the request, mask, pending and control registers read zero, and msg_valid is low.
- R10: Byte strobes are big-endian: reg_strb[0] writes bits 31:24, reg_strb[1] bits 23:16, reg_strb[2] bits 15:8 and reg_strb[3] bits 7:0; offsets 0x14 to 0x1C read zero and ignore writes.
- R11: reg_rdata shows the addressed register in the same cycle as the address, without a clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_IRQ | Interrupt inputs, synchronous to clk |
| reg_addr | input | 5 | Register byte address |
| reg_rd | input | 1 | Read strobe (clears pending when it addresses offset 0x08) |
| reg_wr | input | 1 | Write strobe |
| reg_strb | input | 4 | Big-endian byte strobes for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 32 | Message address, 32-byte aligned |
| msg_data | output | 32 | Message data, values 0 to 31 |
| msg_ready | input | 1 | Message write accepted |

## Verification
The assertions take the interrupt inputs as synchronous to clk and msg_ready as a plain acknowledge that may stay high or low for any number of cycles; they assume nothing about the register bus beyond one strobe at a time. The stimulus drives every input from the falling clock edge, so edges are always seen on a full cycle, and it pulls msg_ready low for long stretches to make the hold and queue behaviour visible. A small configuration of eight inputs and a two-bit queue counter lets the bench sweep every input against every mask and bus-error setting and fill the queue to its limit.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
  localparam int REG_AW = 5;
  localparam int ERR_BIT = 0;
  localparam logic [31:0] MADDR_RST = 32'hFFFB_0003;

  typedef enum logic [2:0] {
    SEL_REQ   = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_PEND  = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_MADDR = 3'd4
  } reg_sel_e;

  // Big-endian lanes: strobe bit k covers the byte at address offset k.
  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  strb);
    logic [31:0] r;
    r = old_v;
    for (int k = 0; k < 4; k++) begin
      if (strb[k]) r[31-8*k -: 8] = new_v[31-8*k -: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/msgirq_edge.sv
module msgirq_edge #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_prev,
  output logic [NUM_IRQ-1:0] rise
);
  logic [NUM_IRQ-1:0] prev_d;

  always_comb begin
    prev_d = irq_in;
    rise   = irq_in & ~irq_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_prev <= '0;
    else        irq_prev <= prev_d;
  end
endmodule

// File: rtl/msgirq_regs.sv
module msgirq_regs
  import msgirq_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [3:0]         reg_strb,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_IRQ-1:0] rise,
  output logic [NUM_IRQ-1:0] pend_q,
  output logic [NUM_IRQ-1:0] req_q,
  output logic               ctrl_err,
  output logic [31:0]        maddr_q,
  output logic               irq_event
);
  localparam int IDX_W = REG_AW - 2;

  logic [IDX_W-1:0]   widx;
  logic [31:0]        mask_q, ctrl_q;
  logic [31:0]        mask_d, ctrl_d, maddr_d;
  logic [NUM_IRQ-1:0] pend_d, req_d, hit;
  logic               mask_we, ctrl_we, maddr_we, pend_clr;
  logic [31:0]        pend_x, req_x;

  always_comb begin
    widx     = reg_addr[REG_AW-1:2];
    mask_we  = reg_wr && (widx == SEL_MASK);
    ctrl_we  = reg_wr && (widx == SEL_CTRL);
    maddr_we = reg_wr && (widx == SEL_MADDR);
    pend_clr = (reg_rd || reg_wr) && (widx == SEL_PEND);

    mask_d  = be_merge(mask_q,  reg_wdata, reg_strb);
    ctrl_d  = be_merge(ctrl_q,  reg_wdata, reg_strb);
    maddr_d = be_merge(maddr_q, reg_wdata, reg_strb);

    hit       = rise & mask_q[NUM_IRQ-1:0];
    pend_d    = (pend_clr ? '0 : pend_q) | rise;
    req_d     = req_q | hit;
    ctrl_err  = ctrl_q[ERR_BIT];
    irq_event = (|hit) && !ctrl_q[ERR_BIT];

    pend_x = '0;
    pend_x[NUM_IRQ-1:0] = pend_q;
    req_x = '0;
    req_x[NUM_IRQ-1:0] = req_q;

    case (widx)
      SEL_REQ:   reg_rdata = req_x;
      SEL_MASK:  reg_rdata = mask_q;
      SEL_PEND:  reg_rdata = pend_x;
      SEL_CTRL:  reg_rdata = {31'd0, ctrl_q[ERR_BIT]};
      SEL_MADDR: reg_rdata = maddr_q;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ctrl_q  <= '0;
      maddr_q <= MADDR_RST;
      pend_q  <= '0;
      req_q   <= '0;
    end else begin
      if (mask_we)  mask_q  <= mask_d;
      if (ctrl_we)  ctrl_q  <= ctrl_d;
      if (maddr_we) maddr_q <= maddr_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/msgirq_send.sv
module msgirq_send #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_event,
  input  logic [31:0]      maddr,
  output logic [CNT_W-1:0] q_cnt,
  output logic             msg_valid,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data,
  input  logic             msg_ready
);
  localparam logic [CNT_W-1:0] Q_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] q_d;
  logic             valid_d, launch, inc;

  always_comb begin
    launch  = !msg_valid && (q_cnt != '0);
    inc     = irq_event && (q_cnt != Q_MAX);
    q_d     = q_cnt + CNT_W'(inc) - CNT_W'(launch);
    valid_d = msg_valid;
    if (launch)                      valid_d = 1'b1;
    else if (msg_valid && msg_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cnt     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      q_cnt     <= q_d;
      msg_valid <= valid_d;
      if (launch) begin
        msg_addr <= {maddr[31:5], 5'd0};
        msg_data <= {27'd0, maddr[4:0]};
      end
    end
  end
endmodule

// File: rtl/msgirq_ctrl.sv
module msgirq_ctrl
  import msgirq_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [3:0]         reg_strb,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               msg_valid,
  output logic [31:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic               msg_ready
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_IRQ-1:0] irq_prev, rise, pend_q, req_q;
  logic               ctrl_err, irq_event;
  logic [31:0]        maddr_q;
  logic [CNT_W-1:0]   q_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  msgirq_edge #(.NUM_IRQ(NUM_IRQ)) edge_i (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in),
    .irq_prev(irq_prev), .rise(rise)
  );

  msgirq_regs #(.NUM_IRQ(NUM_IRQ)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_strb(reg_strb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rise(rise), .pend_q(pend_q), .req_q(req_q),
    .ctrl_err(ctrl_err), .maddr_q(maddr_q), .irq_event(irq_event)
  );

  msgirq_send #(.CNT_W(CNT_W)) send_i (
    .clk(clk), .rst_n(rst_sync_n), .irq_event(irq_event), .maddr(maddr_q),
    .q_cnt(q_cnt), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .msg_ready(msg_ready)
  );
endmodule

// File: rtl/msgirq_ctrl_chk.sv
module msgirq_ctrl_chk #(
  parameter int NUM_IRQ = 32,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] irq_prev,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] req_q,
  input logic               ctrl_err,
  input logic [CNT_W-1:0]   q_cnt,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [31:0]        msg_addr,
  input logic [31:0]        msg_data
);
  localparam logic [CNT_W-1:0] Q_MAX = {CNT_W{1'b1}};

  a_r1_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & ~irq_prev)) |=>
      ((pend_q & $past(irq_in & ~irq_prev)) == $past(irq_in & ~irq_prev)));

  a_r2_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & $past(req_q)) == $past(req_q)));

  a_r3_msg_format: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[4:0] == 5'd0) && (msg_data[31:5] == 27'd0));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt == Q_MAX) |=> (q_cnt >= Q_MAX - 1'b1));

  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_err && !msg_valid && (q_cnt == '0)) |=> !msg_valid);
endmodule

bind msgirq_ctrl msgirq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .irq_prev(irq_prev),
  .pend_q(pend_q), .req_q(req_q), .ctrl_err(ctrl_err), .q_cnt(q_cnt),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msgirq_ctrl_tb_top.sv
module msgirq_ctrl_tb_top;
  localparam int NI = 8;
  localparam int CW = 2;
  localparam logic [4:0] A_REQ = 5'h00, A_MASK = 5'h04, A_PEND = 5'h08,
                         A_CTRL = 5'h0C, A_MADDR = 5'h10, A_HOLE = 5'h14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [4:0]    reg_addr = '0;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [3:0]    reg_strb = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid;
  logic [31:0]   msg_addr, msg_data;
  logic          msg_ready = 1'b1;

  int n_vec = 0, n_bad = 0, n_msg = 0;
  logic [31:0] last_addr = '0, last_data = '0;

  always #5 clk = ~clk;

  msgirq_ctrl #(.NUM_IRQ(NI), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_strb(reg_strb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .msg_ready(msg_ready)
  );

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      n_msg     <= n_msg + 1;
      last_addr <= msg_addr;
      last_data <= msg_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_strb = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int i, input int hold);
    @(negedge clk);
    irq_in[i] = 1'b1;
    repeat (hold) @(negedge clk);
    irq_in[i] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", n_vec);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, reqexp, iar, base, a0;
    reqexp = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R9 reset state, R11 read without latency
    rd(A_MADDR, d); chk("R9 maddr", d, 32'hFFFB_0003);
    rd(A_REQ, d);   chk("R9 req", d, 0);
    rd(A_MASK, d);  chk("R9 mask", d, 0);
    rd(A_PEND, d);  chk("R9 pend", d, 0);
    rd(A_CTRL, d);  chk("R9 ctrl", d, 0);
    chk("R9 valid", {31'd0, msg_valid}, 0);

    // Sweep inputs x mask x bus-error: R1 R2 R3 R6 R7
    for (int i = 0; i < NI; i++) begin
      for (int m = 0; m < 2; m++) begin
        for (int e = 0; e < 2; e++) begin
          iar = 32'hA000_0000 + (i << 8) + (i * 4 + m * 2 + e) * 3 + 1;
          wr(A_MADDR, 4'hF, iar);
          wr(A_MASK, 4'hF, m ? (32'd1 << i) : 32'd0);
          wr(A_CTRL, 4'hF, e);
          base = n_msg;
          pulse(i, 3);
          idle(8);
          chk("R3/R6 message count", n_msg - base, (m == 1 && e == 0) ? 1 : 0);
          if (m == 1 && e == 0) begin
            chk("R3 address", last_addr, iar & 32'hFFFF_FFE0);
            chk("R3 data", last_data, iar & 32'h1F);
          end
          rd(A_PEND, d); chk("R1 pending set", d, 32'd1 << i);
          rd(A_PEND, d); chk("R7 clear on read", d, 0);
          if (m == 1) reqexp |= (32'd1 << i);
          rd(A_REQ, d); chk("R2/R6 request", d, reqexp);
        end
      end
    end
    wr(A_CTRL, 4'hF, 0);

    // R2 write to request ignored
    wr(A_REQ, 4'hF, 32'hFFFF_FFFF);
    rd(A_REQ, d); chk("R2 request write ignored", d, reqexp);

    // R4 hold until ready; maddr taken at launch
    wr(A_MASK, 4'hF, 32'h1);
    wr(A_MADDR, 4'hF, 32'h0000_1235);
    msg_ready = 1'b0;
    base = n_msg;
    pulse(0, 1);
    idle(4);
    chk("R4 valid raised", {31'd0, msg_valid}, 1);
    a0 = msg_addr;
    chk("R3 launch addr", a0, 32'h0000_1220);
    wr(A_MADDR, 4'hF, 32'h0000_4447);
    idle(3);
    chk("R4 valid held", {31'd0, msg_valid}, 1);
    chk("R4 addr stable", msg_addr, a0);
    chk("R4 data stable", msg_data, 32'h15);
    @(negedge clk); msg_ready = 1'b1;
    idle(4);
    chk("R4 one message", n_msg - base, 1);
    chk("R4 sent data", last_data, 32'h15);

    // R5 queue with saturation: 5 events, 1 in flight + 3 queued
    msg_ready = 1'b0;
    base = n_msg;
    for (int k = 0; k < 5; k++) pulse(0, 1);
    idle(3);
    @(negedge clk); msg_ready = 1'b1;
    idle(20);
    chk("R5 queued messages", n_msg - base, 4);
    chk("R5 last data", last_data, 32'h07);
    chk("R5 idle after drain", {31'd0, msg_valid}, 0);
    rd(A_PEND, d);

    // R7 write clears pending regardless of data
    wr(A_MASK, 4'hF, 0);
    pulse(2, 1);
    idle(2);
    wr(A_PEND, 4'b0001, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R7 clear on write", d, 0);

    // R8 control read shows bit 0 only
    wr(A_CTRL, 4'hF, 32'hFFFF_FFFE);
    rd(A_CTRL, d); chk("R8 ctrl other bits", d, 0);
    wr(A_CTRL, 4'hF, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R8 ctrl bit0", d, 1);
    wr(A_MASK, 4'hF, 32'hFF);
    base = n_msg;
    pulse(5, 2);
    idle(8);
    chk("R6 suppressed", n_msg - base, 0);
    wr(A_CTRL, 4'hF, 0);
    rd(A_PEND, d);

    // R10 big-endian strobes and unmapped offsets
    wr(A_MASK, 4'hF, 0);
    wr(A_MASK, 4'b0001, 32'hA5A5_A5A5);
    rd(A_MASK, d); chk("R10 strobe0 top byte", d, 32'hA500_0000);
    wr(A_MASK, 4'b1000, 32'h3C3C_3C3C);
    rd(A_MASK, d); chk("R10 strobe3 low byte", d, 32'hA500_003C);
    wr(A_MASK, 4'b0110, 32'h1122_3344);
    rd(A_MASK, d); chk("R10 middle lanes", d, 32'hA522_333C);
    wr(A_HOLE, 4'hF, 32'hDEAD_BEEF);
    rd(A_HOLE, d); chk("R10 hole reads zero", d, 0);
    rd(A_MASK, d); chk("R10 hole write ignored", d, 32'hA522_333C);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule